// File: doc/BRIEF.md
# Serial bus byte transmit buffer

This block feeds a serial bus transmitter one byte at a time. The CPU writes a byte into an 8-bit holding register. At each load point the block moves that byte into a shift register, and the shifter drives it onto a single output line, most significant bit first. A bit-enable strobe stands in for the bus timing and moves the line on by one bit per strobe.

After every eighth bit the block waits for an acknowledge result. Its next step depends on that result and on the transfer mode:
- In individual mode it either moves on to the next byte or sends the same byte again.
- In broadcast mode it always moves on.

A frame starts on a `start` pulse. The frame length and mode are captured at that moment.

Each time the shifter takes a byte from the holding register, a one-cycle service interrupt tells the CPU that room is free for the next byte. No service interrupt is raised when the byte taken is the last one the frame will need. If the CPU is late and the holding register is empty at a load point, the frame is aborted with an error interrupt. The frame is also aborted once the retransmit allowance is used up. A completed frame ends with a one-cycle done pulse.

Top module: `sbus_tx_buffer`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` in the 8-bit holding register and sets `dr_full` from the next cycle. `dr_full` clears in the cycle after the shifter takes the byte. A write in the same cycle as a take wins: `dr_full` stays 1 and the new value is held, while the shifter takes the old value.
- R2: In the cycle after a byte is taken, `ser_out` shows its bit 7. Each `bit_en` pulse while shifting advances `ser_out` by one bit, toward bit 0. After the eighth `bit_en` the block waits for `ack_valid`. `ser_out` is 1 whenever `busy` is 0.
- R3: `irq_svc` pulses for exactly one cycle, in the cycle after the shifter takes a byte from the holding register. This includes the first byte, taken on `start`.
- R4: No `irq_svc` pulse is raised when the byte taken is the last byte of the frame, or when it is the 32nd byte of the frame.
- R5: With `bcast`=0 captured at start, `ack_valid` together with `ack_ok`=0 restarts the same byte from bit 7. The holding register is not taken, `dr_full` is unchanged and `irq_svc` stays 0.
- R6: `retry_max` is captured at start and is the number of retransmissions allowed per byte. A nack that arrives after that many retransmissions of the current byte pulses `irq_err` and returns the block to idle.
- R7: With `bcast`=1 captured at start, `ack_ok` is ignored. Every `ack_valid` is treated as an acknowledge, and no byte is ever retransmitted.
- R8: `frame_len` is captured at start. A value of 0 counts as 1, and values above 32 count as 32. When the final byte is acknowledged, `done` pulses for one cycle and `busy` falls.
- R9: Underrun: at a load point where `dr_full` is 0, `irq_err` pulses for one cycle, nothing is loaded, `busy` is 0 and `ser_out` stays 1. A load point is either `start` while idle, or the acknowledge of a non-final byte.
- R10: After reset, `busy`, `dr_full`, `irq_svc`, `irq_err` and `done` are 0, and `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for the holding register |
| wr_data | input | 8 | Byte written by the CPU |
| start | input | 1 | Begin a frame (ignored while busy) |
| bcast | input | 1 | 1 = broadcast transfer, 0 = individual transfer |
| frame_len | input | 6 | Number of bytes in the frame |
| retry_max | input | 4 | Allowed retransmissions per byte |
| bit_en | input | 1 | Bit strobe, advances the line by one bit |
| ack_valid | input | 1 | Acknowledge result present for the current byte |
| ack_ok | input | 1 | 1 = acknowledge, 0 = nack |
| ser_out | output | 1 | Serial data line |
| busy | output | 1 | Frame in progress |
| dr_full | output | 1 | Holding register holds an unsent byte |
| irq_svc | output | 1 | Per-byte service interrupt pulse |
| irq_err | output | 1 | Communication error interrupt pulse |
| done | output | 1 | Frame complete pulse |

## Verification
The bench targets several corner cases, and each maps to a specific failure:
- **Retransmission after a nack.** A design that reloaded from the holding register would send the next byte too early and clear `dr_full`. A design that raised the service interrupt would inflate the interrupt count.
- **Frame lengths of 0, 1, 32 and above 32.** A block that forgot the 32-byte cap, or did not suppress the interrupt on the final or 32nd load, would send extra bytes or count one interrupt too many.
- **A CPU write in the same cycle as a load.** A register that let the take win would lose the queued byte.
- **Broadcast frames with nacks.** These expose a design that wrongly retransmits.
- **Underrun at the first and at a later load point, and retry exhaustion.** Each must end in a single error pulse with the line left high and `busy` low, not a hung frame.

// File: rtl/sbus_tx_pkg.sv
package sbus_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_ACK   = 2'd2
  } tx_state_e;
endpackage

// File: rtl/sbus_tx_holdreg.sv
module sbus_tx_holdreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] dr_q,
  output logic          full_q
);
  // A write always wins over a take in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q   <= '0;
      full_q <= 1'b0;
    end else if (wr_en) begin
      dr_q   <= wr_data;
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_tx_shifter.sv
module sbus_tx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_new,
  input  logic          reload,
  input  logic          shift,
  input  logic [DW-1:0] new_byte,
  output logic          sout,
  output logic          byte_done
);
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0]    shreg;
  logic [DW-1:0]    copy_q;
  logic [BIT_W-1:0] bcnt;

  // The shift register fills with ones, so the line rests high after the last bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      copy_q <= '0;
      bcnt   <= '0;
    end else if (load_new) begin
      shreg  <= new_byte;
      copy_q <= new_byte;
      bcnt   <= '0;
    end else if (reload) begin
      shreg  <= copy_q;
      bcnt   <= '0;
    end else if (shift) begin
      shreg  <= {shreg[DW-2:0], 1'b1};
      bcnt   <= bcnt + BIT_W'(1);
    end
  end

  assign sout      = shreg[DW-1];
  assign byte_done = shift && (bcnt == BIT_W'(DW - 1));
endmodule

// File: rtl/sbus_tx_seq.sv
module sbus_tx_seq
  import sbus_tx_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  parameter int LEN_W     = 6,
  parameter int RETRY_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               bcast,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               bit_en,
  input  logic               ack_valid,
  input  logic               ack_ok,
  input  logic               full,
  input  logic               byte_done,
  output logic               take,
  output logic               reload,
  output logic               shift,
  output logic               busy,
  output logic               irq_svc,
  output logic               irq_err,
  output logic               done
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  tx_state_e          state;
  logic [CNT_W-1:0]   idx;
  logic [CNT_W-1:0]   len_q;
  logic [CNT_W-1:0]   len_eff;
  logic [CNT_W-1:0]   next_idx;
  logic [CNT_W-1:0]   next_len;
  logic [RETRY_W-1:0] retry_cnt;
  logic [RETRY_W-1:0] rmax_q;
  logic               bcast_q;
  logic               underrun;
  logic               fail;
  logic               fin;

  // Clamp the requested length to the range 1 .. MAX_BYTES.
  always_comb begin
    if (frame_len == '0)
      len_eff = CNT_W'(1);
    else if (frame_len > LEN_W'(MAX_BYTES))
      len_eff = CNT_W'(MAX_BYTES);
    else
      len_eff = CNT_W'(frame_len);
  end

  assign next_idx = (state == ST_IDLE) ? CNT_W'(1) : idx + CNT_W'(1);
  assign next_len = (state == ST_IDLE) ? len_eff : len_q;

  always_comb begin
    take     = 1'b0;
    reload   = 1'b0;
    underrun = 1'b0;
    fail     = 1'b0;
    fin      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (full) take = 1'b1;
          else      underrun = 1'b1;
        end
      end
      ST_ACK: begin
        if (ack_valid) begin
          if (bcast_q || ack_ok) begin
            if (idx == len_q) fin = 1'b1;
            else if (full)    take = 1'b1;
            else              underrun = 1'b1;
          end else if (retry_cnt == rmax_q) begin
            fail = 1'b1;
          end else begin
            reload = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign shift = (state == ST_SHIFT) && bit_en;
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      len_q     <= CNT_W'(1);
      bcast_q   <= 1'b0;
      rmax_q    <= '0;
      retry_cnt <= '0;
      irq_svc   <= 1'b0;
      irq_err   <= 1'b0;
      done      <= 1'b0;
    end else begin
      irq_svc <= take && (next_idx != next_len) && (next_idx != CNT_W'(MAX_BYTES));
      irq_err <= underrun || fail;
      done    <= fin;
      if (take) begin
        state     <= ST_SHIFT;
        idx       <= next_idx;
        retry_cnt <= '0;
        if (state == ST_IDLE) begin
          len_q   <= len_eff;
          bcast_q <= bcast;
          rmax_q  <= retry_max;
        end
      end else if (reload) begin
        state     <= ST_SHIFT;
        retry_cnt <= retry_cnt + RETRY_W'(1);
      end else if (underrun || fail || fin) begin
        state <= ST_IDLE;
      end else if (byte_done) begin
        state <= ST_ACK;
      end
    end
  end
endmodule

// File: rtl/sbus_tx_buffer.sv
module sbus_tx_buffer #(
  parameter int DW        = 8,
  parameter int MAX_BYTES = 32,
  parameter int LEN_W     = 6,
  parameter int RETRY_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               start,
  input  logic               bcast,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               bit_en,
  input  logic               ack_valid,
  input  logic               ack_ok,
  output logic               ser_out,
  output logic               busy,
  output logic               dr_full,
  output logic               irq_svc,
  output logic               irq_err,
  output logic               done
);
  logic [DW-1:0] dr_q;
  logic          take;
  logic          reload;
  logic          shift;
  logic          byte_done;

  sbus_tx_holdreg #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .dr_q    (dr_q),
    .full_q  (dr_full)
  );

  sbus_tx_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_new  (take),
    .reload    (reload),
    .shift     (shift),
    .new_byte  (dr_q),
    .sout      (ser_out),
    .byte_done (byte_done)
  );

  sbus_tx_seq #(
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .RETRY_W   (RETRY_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bcast     (bcast),
    .frame_len (frame_len),
    .retry_max (retry_max),
    .bit_en    (bit_en),
    .ack_valid (ack_valid),
    .ack_ok    (ack_ok),
    .full      (dr_full),
    .byte_done (byte_done),
    .take      (take),
    .reload    (reload),
    .shift     (shift),
    .busy      (busy),
    .irq_svc   (irq_svc),
    .irq_err   (irq_err),
    .done      (done)
  );
endmodule

// File: rtl/sbus_tx_buffer_chk.sv
module sbus_tx_buffer_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic bit_en,
  input logic ack_valid,
  input logic ser_out,
  input logic busy,
  input logic dr_full,
  input logic irq_svc,
  input logic irq_err,
  input logic done
);
  p_full_on_write_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> dr_full);

  p_line_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);

  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(bit_en) && !$past(ack_valid)) |-> $stable(ser_out));

  p_svc_busy_r3: assert property (@(posedge clk) disable iff (rst)
    irq_svc |-> busy);

  p_svc_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    irq_svc |=> !irq_svc || $past(ack_valid));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !irq_err && !irq_svc);

  p_err_idle_r9: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> !busy && !irq_svc);
endmodule

bind sbus_tx_buffer sbus_tx_buffer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .bit_en    (bit_en),
  .ack_valid (ack_valid),
  .ser_out   (ser_out),
  .busy      (busy),
  .dr_full   (dr_full),
  .irq_svc   (irq_svc),
  .irq_err   (irq_err),
  .done      (done)
);

// File: tb/sbus_tx_buffer_tb.sv
`timescale 1ns/1ps
module sbus_tx_buffer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic       bcast = 1'b0;
  logic [5:0] frame_len = '0;
  logic [3:0] retry_max = '0;
  logic       bit_en = 1'b0;
  logic       ack_valid = 1'b0;
  logic       ack_ok = 1'b0;
  logic       ser_out, busy, dr_full, irq_svc, irq_err, done;

  int checks = 0;
  int failures = 0;
  int n_svc = 0;
  int n_err = 0;
  int n_done = 0;

  always #2 clk = ~clk;

  sbus_tx_buffer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .start(start),
    .bcast(bcast), .frame_len(frame_len), .retry_max(retry_max),
    .bit_en(bit_en), .ack_valid(ack_valid), .ack_ok(ack_ok),
    .ser_out(ser_out), .busy(busy), .dr_full(dr_full),
    .irq_svc(irq_svc), .irq_err(irq_err), .done(done)
  );

  // Pulses are counted at the edge that ends them.
  always @(posedge clk) begin
    if (!rst) begin
      if (irq_svc) n_svc  <= n_svc + 1;
      if (irq_err) n_err  <= n_err + 1;
      if (done)    n_done <= n_done + 1;
    end
  end

  // {len[5:0], bcast, retry_max[3:0], nack_mask[7:0], seed[7:0]}
  localparam int NV = 7;
  localparam logic [26:0] VECS [0:NV-1] = '{
    {6'd1,  1'b0, 4'd1, 8'h00, 8'hA5},
    {6'd4,  1'b0, 4'd1, 8'h05, 8'h3C},
    {6'd5,  1'b1, 4'd0, 8'h1F, 8'h81},
    {6'd32, 1'b0, 4'd2, 8'h80, 8'h5A},
    {6'd45, 1'b0, 4'd1, 8'h00, 8'hC3},
    {6'd0,  1'b1, 4'd0, 8'h01, 8'h7E},
    {6'd8,  1'b0, 4'd3, 8'hFF, 8'h12}
  };

  function automatic logic [7:0] byte_of(input logic [7:0] seed, input int b);
    return seed ^ (8'(b) * 8'h3B) ^ 8'(b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick(input int len, input logic bc, input logic [3:0] rm);
    frame_len = 6'(len); bcast = bc; retry_max = rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Shift one byte out, comparing each bit; returns mismatch count.
  task automatic shift_byte(input logic [7:0] exp, output int bad);
    bad = 0;
    for (int i = 7; i >= 0; i--) begin
      if (ser_out !== exp[i]) bad++;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic give_ack(input logic ok);
    ack_valid = 1'b1; ack_ok = ok;
    @(negedge clk);
    ack_valid = 1'b0; ack_ok = 1'b0;
  endtask

  task automatic run_vec(input logic [26:0] v);
    int len, n, bad, svc0, done0, err0, att;
    logic bc;
    logic [3:0] rm;
    logic [7:0] mask, seed, exp;
    len = int'(v[26:21]); bc = v[20]; rm = v[19:16]; mask = v[15:8]; seed = v[7:0];
    n = (len == 0) ? 1 : (len > 32 ? 32 : len);
    svc0 = n_svc; done0 = n_done; err0 = n_err; bad = 0;
    cpu_write(byte_of(seed, 0));
    kick(len, bc, rm);
    for (int b = 0; b < n; b++) begin
      att = (!bc && b < 8 && mask[b]) ? 2 : 1;
      exp = byte_of(seed, b);
      for (int a = 0; a < att; a++) begin
        for (int i = 7; i >= 0; i--) begin
          if (a == 0 && i == 7 && b + 1 < n) begin
            wr_en = 1'b1; wr_data = byte_of(seed, b + 1);
          end
          if (ser_out !== exp[i]) bad++;
          bit_en = 1'b1;
          @(negedge clk);
          bit_en = 1'b0; wr_en = 1'b0;
        end
        give_ack(!(b < 8 && mask[b] && a == 0));
      end
    end
    @(negedge clk);
    chk(bad == 0, "R2/R5/R7 serial bits", bad, 0);
    chk(n_svc - svc0 == n - 1, "R3/R4 service irq count", n_svc - svc0, n - 1);
    chk(n_done - done0 == 1, "R8 done pulses", n_done - done0, 1);
    chk(n_err == err0, "R6 no error", n_err - err0, 0);
    chk(!busy && ser_out, "R8 idle after frame", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bad, e0, d0;
    do_reset();
    // R10 reset state
    chk(!busy && ser_out && !dr_full, "R10 reset outputs", {busy, ser_out, dr_full}, 3'b010);
    chk(!irq_svc && !irq_err && !done, "R10 reset pulses", {irq_svc, irq_err, done}, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R1/R3/R4: write collides with the first take; second take is the last byte.
    do_reset();
    cpu_write(8'h80);
    chk(dr_full, "R1 full after write", dr_full, 1);
    wr_en = 1'b1; wr_data = 8'h11;
    kick(2, 1'b0, 4'd0);
    wr_en = 1'b0;
    chk(irq_svc, "R3 svc on first take", irq_svc, 1);
    chk(dr_full, "R1 write wins over take", dr_full, 1);
    chk(ser_out, "R2 msb shown after take", ser_out, 1);
    shift_byte(8'h80, bad);
    chk(bad == 0, "R2 first byte bits", bad, 0);
    give_ack(1'b1);
    chk(!irq_svc, "R4 no svc on last byte", irq_svc, 0);
    chk(!dr_full, "R1 full clears on take", dr_full, 0);
    shift_byte(8'h11, bad);
    chk(bad == 0, "R1 queued byte sent", bad, 0);
    d0 = n_done;
    give_ack(1'b1);
    chk(done, "R8 done pulse", done, 1);
    @(negedge clk);
    chk(n_done == d0 + 1 && !done, "R8 done single cycle", n_done - d0, 1);

    // R9 underrun at start
    do_reset();
    kick(3, 1'b0, 4'd0);
    chk(irq_err && !busy && ser_out, "R9 underrun at start", {irq_err, busy, ser_out}, 3'b101);

    // R9 underrun mid-frame
    do_reset();
    cpu_write(8'h5C);
    kick(3, 1'b0, 4'd0);
    shift_byte(8'h5C, bad);
    give_ack(1'b1);
    chk(irq_err && !busy && ser_out, "R9 underrun mid-frame", {irq_err, busy, ser_out}, 3'b101);

    // R5/R6 nack retransmit then retry exhaustion
    do_reset();
    cpu_write(8'hC6);
    kick(2, 1'b0, 4'd1);
    cpu_write(8'h39);
    shift_byte(8'hC6, bad);
    give_ack(1'b0);
    chk(!irq_svc && dr_full && busy, "R5 nack keeps register", {irq_svc, dr_full, busy}, 3'b011);
    shift_byte(8'hC6, bad);
    chk(bad == 0, "R5 same byte resent", bad, 0);
    e0 = n_err;
    give_ack(1'b0);
    chk(irq_err && !busy, "R6 retry limit error", {irq_err, busy}, 2'b10);
    @(negedge clk);
    chk(n_err == e0 + 1 && ser_out, "R6 single error, line high", n_err - e0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule